// File: doc/BRIEF.md
# Stream Packet Pattern Checker

This block sits on the receiving end of an AXI4-Stream link and scores each incoming packet against a fixed walking-one pattern. The same pattern is produced by a companion traffic source. Beat k of a packet is expected to carry a word with only bit (k mod DATA_W) set. The expected length of a packet, in beats, is the parameter PKT_BEATS. A packet is good only when it has exactly PKT_BEATS beats, every beat matches, and tlast is on the final beat. Any other packet is an error.

The block has two saturating counters, one for good packets and one for error packets, and both are status outputs. When a link comes up, the first packets may be cut short or misaligned. Such packets are counted as errors. The block does not stall or lose its place on them, because the expected pattern restarts after every tlast. The block never applies backpressure.

A synchronous active-high soft reset clears both counters and restarts the expected pattern. The hard reset does the same. Data width, packet length and counter width are all parameters. The data width is meant to be 8, 64 or 256 bits.

Top module: `pkt_pattern_checker`

## Requirements
- R1: s_tready is 1 in every cycle, including during reset.
- R2: A beat is taken only on a clock edge where s_tvalid is 1. Beat k (counted from 0 after the last tlast) is expected to equal a DATA_W-bit word with only bit (k mod DATA_W) set. When s_tvalid is 0, s_tdata and s_tlast have no effect.
- R3: A packet of exactly PKT_BEATS matching beats, with tlast on beat PKT_BEATS-1, raises good_count by 1. The new value is visible right after the clock edge that takes the tlast beat.
- R4: A packet in which any beat differs from its expected word raises err_count by 1 at its tlast beat. good_count does not change.
- R5: A packet whose tlast arrives on a beat before beat PKT_BEATS-1 raises err_count by 1.
- R6: If beat PKT_BEATS-1 has no tlast, the packet continues up to the next tlast. The extra beats are not compared. Exactly one error is counted, at that tlast.
- R7: Each accepted tlast beat changes exactly one of the two counters. In cycles without an accepted tlast beat, neither counter changes.
- R8: The expected pattern restarts at beat 0 after every tlast, so a correct packet that follows a bad one counts as good.
- R9: Both counters saturate at 2^CNT_W-1 and hold there.
- R10: soft_rst is synchronous and active high. It sets both counters to 0 at the next edge and restarts the expected pattern at beat 0. A beat presented while soft_rst is high is discarded.
- R11: rst is a synchronous, active-high hard reset with the same effect as soft_rst. After it, both counters read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous hard reset, active high |
| soft_rst | input | 1 | Synchronous soft reset, active high: clears the counters and restarts the pattern |
| s_tdata | input | DATA_W | Stream data |
| s_tvalid | input | 1 | Stream beat valid |
| s_tlast | input | 1 | Last beat of a packet |
| s_tready | output | 1 | Always 1 |
| good_count | output | CNT_W | Saturating count of good packets |
| err_count | output | CNT_W | Saturating count of error packets |

## Verification
The assertions check every cycle for the following:
- a packet-end event occurs only on an accepted tlast beat;
- a premature tlast is always scored as an error;
- the beat index never goes past its overrun value;
- the counters move by exactly one or hold;
- the counters stay at their maximum once saturated;
- the counters read zero after a soft reset.

Only the bench scenarios can show that the walking-one pattern is the one compared. The same holds for mismatches, overlong packets scored once, gaps with idle garbage, and recovery after a bad or interrupted packet. These scenarios also show that both counts land on the values the requirements predict.

// File: rtl/pkt_pattern_pkg.sv
package pkt_pattern_pkg;

  // Bit position that is set in beat 'idx' of the walking-one pattern.
  function automatic int unsigned pattern_bit(int unsigned idx, int unsigned width);
    return idx % width;
  endfunction

  // Next value of a saturating up-counter given its current value and limit.
  function automatic logic [63:0] sat_step(logic [63:0] cur, logic [63:0] limit);
    return (cur == limit) ? cur : cur + 64'd1;
  endfunction

endpackage

// File: rtl/chk_beat_track.sv
module chk_beat_track
  import pkt_pattern_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int PKT_BEATS = 16,
  localparam int IDX_W    = $clog2(PKT_BEATS + 1)
) (
  input  logic              clk,
  input  logic              clear,
  input  logic              beat_ok,
  input  logic [DATA_W-1:0] tdata,
  input  logic              tlast,
  output logic              good_ev,
  output logic              err_ev,
  output logic [IDX_W-1:0]  beat_idx
);

  logic [IDX_W-1:0]  idx_q;
  logic              bad_q;
  logic [DATA_W-1:0] exp_word;
  logic              in_range;
  logic              at_final;
  logic              beat_bad;
  logic              pkt_bad;
  logic              end_ev;

  always_comb begin
    in_range = idx_q < IDX_W'(PKT_BEATS);
    at_final = idx_q == IDX_W'(PKT_BEATS - 1);
    exp_word = DATA_W'(1) << pattern_bit(32'(idx_q), DATA_W);
    // In overrun, no comparison is made: the packet is already marked bad.
    beat_bad = !in_range
             || (tdata != exp_word)
             || (tlast && !at_final)
             || (!tlast && at_final);
    pkt_bad  = bad_q || beat_bad;
    end_ev   = beat_ok && tlast && !clear;
    good_ev  = end_ev && !pkt_bad;
    err_ev   = end_ev && pkt_bad;
  end

  always_ff @(posedge clk) begin
    if (clear) begin
      idx_q <= '0;
      bad_q <= 1'b0;
    end else if (beat_ok) begin
      if (tlast) begin
        idx_q <= '0;
        bad_q <= 1'b0;
      end else begin
        idx_q <= in_range ? idx_q + 1'b1 : idx_q;
        bad_q <= pkt_bad;
      end
    end
  end

  assign beat_idx = idx_q;

endmodule

// File: rtl/chk_sat_counter.sv
module chk_sat_counter
  import pkt_pattern_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         clear,
  input  logic         inc,
  output logic [W-1:0] count
);

  localparam logic [W-1:0] LIMIT = '1;

  logic [63:0] nxt;

  always_comb nxt = sat_step(64'(count), 64'(LIMIT));

  always_ff @(posedge clk) begin
    if (clear)    count <= '0;
    else if (inc) count <= nxt[W-1:0];
  end

endmodule

// File: rtl/pkt_pattern_checker.sv
module pkt_pattern_checker #(
  parameter int DATA_W    = 64,
  parameter int PKT_BEATS = 16,
  parameter int CNT_W     = 32,
  localparam int IDX_W    = $clog2(PKT_BEATS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic [DATA_W-1:0] s_tdata,
  input  logic              s_tvalid,
  input  logic              s_tlast,
  output logic              s_tready,
  output logic [CNT_W-1:0]  good_count,
  output logic [CNT_W-1:0]  err_count
);

  logic             clear;
  logic             beat_ok;
  logic             good_ev;
  logic             err_ev;
  logic [IDX_W-1:0] beat_idx;
  logic [1:0]       ev_vec;
  logic [CNT_W-1:0] cnt_vec [2];

  assign s_tready = 1'b1;
  assign clear    = rst || soft_rst;
  assign beat_ok  = s_tvalid && s_tready;

  chk_beat_track #(
    .DATA_W   (DATA_W),
    .PKT_BEATS(PKT_BEATS)
  ) u_track (
    .clk     (clk),
    .clear   (clear),
    .beat_ok (beat_ok),
    .tdata   (s_tdata),
    .tlast   (s_tlast),
    .good_ev (good_ev),
    .err_ev  (err_ev),
    .beat_idx(beat_idx)
  );

  assign ev_vec = {err_ev, good_ev};

  for (genvar g = 0; g < 2; g++) begin : g_cnt
    chk_sat_counter #(.W(CNT_W)) u_cnt (
      .clk  (clk),
      .clear(clear),
      .inc  (ev_vec[g]),
      .count(cnt_vec[g])
    );
  end

  assign good_count = cnt_vec[0];
  assign err_count  = cnt_vec[1];

endmodule

// File: rtl/pkt_pattern_checker_sva.sv
module pkt_pattern_checker_sva #(
  parameter int DATA_W    = 64,
  parameter int PKT_BEATS = 16,
  parameter int CNT_W     = 32,
  localparam int IDX_W    = $clog2(PKT_BEATS + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             soft_rst,
  input logic             s_tvalid,
  input logic             s_tlast,
  input logic             good_ev,
  input logic             err_ev,
  input logic [IDX_W-1:0] beat_idx,
  input logic [CNT_W-1:0] good_count,
  input logic [CNT_W-1:0] err_count
);

  localparam logic [CNT_W-1:0] CMAX = '1;

  assert_event_on_tlast_R7: assert property (@(posedge clk) disable iff (rst)
    (good_ev || err_ev) |-> (s_tvalid && s_tlast && !soft_rst));

  assert_short_is_error_R5: assert property (@(posedge clk) disable iff (rst || soft_rst)
    (s_tvalid && s_tlast && (beat_idx < IDX_W'(PKT_BEATS - 1))) |-> err_ev);

  assert_idx_bounded_R6: assert property (@(posedge clk) disable iff (rst)
    beat_idx <= IDX_W'(PKT_BEATS));

  assert_good_step_R3: assert property (@(posedge clk) disable iff (rst || soft_rst)
    (good_ev && good_count != CMAX) |=> good_count == $past(good_count) + 1'b1);

  assert_err_step_R4: assert property (@(posedge clk) disable iff (rst || soft_rst)
    (err_ev && err_count != CMAX) |=> err_count == $past(err_count) + 1'b1);

  assert_good_hold_R7: assert property (@(posedge clk) disable iff (rst || soft_rst)
    !good_ev |=> $stable(good_count));

  assert_err_hold_R7: assert property (@(posedge clk) disable iff (rst || soft_rst)
    !err_ev |=> $stable(err_count));

  assert_good_sat_R9: assert property (@(posedge clk) disable iff (rst || soft_rst)
    (good_count == CMAX) |=> good_count == CMAX);

  assert_err_sat_R9: assert property (@(posedge clk) disable iff (rst || soft_rst)
    (err_count == CMAX) |=> err_count == CMAX);

  assert_soft_clear_R10: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (good_count == '0 && err_count == '0));

endmodule

bind pkt_pattern_checker pkt_pattern_checker_sva #(
  .DATA_W   (DATA_W),
  .PKT_BEATS(PKT_BEATS),
  .CNT_W    (CNT_W)
) u_sva (
  .clk       (clk),
  .rst       (rst),
  .soft_rst  (soft_rst),
  .s_tvalid  (s_tvalid),
  .s_tlast   (s_tlast),
  .good_ev   (good_ev),
  .err_ev    (err_ev),
  .beat_idx  (beat_idx),
  .good_count(good_count),
  .err_count (err_count)
);

// File: tb/test_pkt_pattern_checker.sv
`timescale 1ns/1ps
module test_pkt_pattern_checker;

  localparam int DW = 64;
  localparam int PB = 4;
  localparam int CW = 4;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          soft_rst = 1'b0;
  logic [DW-1:0] s_tdata = '0;
  logic          s_tvalid = 1'b0;
  logic          s_tlast = 1'b0;
  logic          s_tready;
  logic [CW-1:0] good_count;
  logic [CW-1:0] err_count;

  int total = 0;
  int bad = 0;
  int exp_good = 0;
  int exp_err = 0;

  always #2 clk = ~clk;

  pkt_pattern_checker #(.DATA_W(DW), .PKT_BEATS(PB), .CNT_W(CW)) i_pkt_pattern_checker (
    .clk(clk), .rst(rst), .soft_rst(soft_rst),
    .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tlast(s_tlast),
    .s_tready(s_tready), .good_count(good_count), .err_count(err_count)
  );

  // Bench view of the pattern: beat k carries a single 1 at bit k mod DW.
  function automatic logic [DW-1:0] want_word(int k);
    logic [DW-1:0] w = '0;
    w[k % DW] = 1'b1;
    return w;
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_counts(string req);
    chk({req, " good"}, int'(good_count), exp_good);
    chk({req, " err"},  int'(err_count),  exp_err);
  endtask

  task automatic beat(logic [DW-1:0] d, bit last);
    s_tvalid = 1'b1; s_tdata = d; s_tlast = last;
    @(negedge clk);
    s_tvalid = 1'b0; s_tlast = 1'b0; s_tdata = '0;
  endtask

  // n beats; beat flip_at gets an extra bit flipped (-1: none); tlast on beat n-1.
  task automatic send_pkt(int n, int flip_at);
    for (int k = 0; k < n; k++) begin
      logic [DW-1:0] d = want_word(k);
      if (k == flip_at) d = d ^ 64'h8000_0000_0000_0001;
      beat(d, k == n - 1);
    end
  endtask

  task automatic do_soft_rst();
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    exp_good = 0; exp_err = 0;
  endtask

  task automatic t_reset();
    chk("R11 reset good", int'(good_count), 0);
    chk("R11 reset err",  int'(err_count),  0);
    chk("R1 tready", int'(s_tready), 1);
  endtask

  task automatic t_good();
    for (int p = 0; p < 3; p++) begin
      send_pkt(PB, -1);
      exp_good++;
      chk_counts("R3 R2 good packet");
    end
    chk("R1 tready after traffic", int'(s_tready), 1);
  endtask

  task automatic t_mismatch();
    send_pkt(PB, 2);
    exp_err++;
    chk_counts("R4 mismatch");
    send_pkt(PB, 0);
    exp_err++;
    chk_counts("R4 mismatch first beat");
  endtask

  task automatic t_short();
    send_pkt(2, -1);
    exp_err++;
    chk_counts("R5 short");
    send_pkt(1, -1);
    exp_err++;
    chk_counts("R5 single beat");
  endtask

  task automatic t_long();
    send_pkt(PB + 3, -1);
    exp_err++;
    chk_counts("R6 long once");
  endtask

  task automatic t_restart();
    send_pkt(PB, 1);
    exp_err++;
    send_pkt(PB, -1);
    exp_good++;
    chk_counts("R8 restart after bad");
  endtask

  task automatic t_gaps();
    for (int k = 0; k < PB; k++) begin
      // idle cycles with garbage and tlast while valid is low
      s_tvalid = 1'b0; s_tlast = 1'b1; s_tdata = '1;
      @(negedge clk);
      chk_counts("R7 idle no change");
      beat(want_word(k), k == PB - 1);
    end
    exp_good++;
    chk_counts("R2 gapped packet");
  endtask

  task automatic t_soft();
    do_soft_rst();
    chk_counts("R10 soft clear");
    send_pkt(2, -1);
    exp_err++;
    // half a packet, then soft reset, with a beat presented in the reset cycle
    beat(want_word(0), 1'b0);
    beat(want_word(1), 1'b0);
    soft_rst = 1'b1; s_tvalid = 1'b1; s_tdata = want_word(2); s_tlast = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0; s_tvalid = 1'b0; s_tlast = 1'b0;
    exp_good = 0; exp_err = 0;
    chk_counts("R10 beat during soft reset dropped");
    send_pkt(PB, -1);
    exp_good++;
    chk_counts("R10 pattern restarted");
  endtask

  task automatic t_sat();
    do_soft_rst();
    for (int p = 0; p < CMAX + 3; p++) send_pkt(PB, -1);
    exp_good = CMAX;
    chk_counts("R9 good saturates");
    for (int p = 0; p < CMAX + 2; p++) send_pkt(PB, 3);
    exp_err = CMAX;
    chk_counts("R9 err saturates");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 tready in reset", int'(s_tready), 1);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_good();
    t_mismatch();
    t_short();
    t_long();
    t_restart();
    t_gaps();
    t_soft();
    t_sat();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule